// File: doc/BRIEF.md
# Interlaced Field Parity Detector

This block decides which field of an interlaced video signal is arriving. It works on a composite sync bit and a vertical pulse that have both already been brought into the local clock domain. A gap timer measures how long sync has been low since the last pulse. A parity flop flips on every rising edge of sync. It returns to zero whenever a gap is at least as long as a programmable threshold. The threshold is set between a half-line spacing and a full-line spacing, so only full-line gaps clear the flop.

Inside the vertical interval, pulses come every half line. The flop then counts them modulo two, starting from the last full-line gap. A field that ends with a half line adds one pulse to that count. The parity held at the start of the vertical pulse therefore alternates from field to field. The block captures that parity on the rising edge of the vertical pulse and holds it as the field level until the next vertical pulse. A high level marks the field that ends with the half line (odd), and a low level marks the other (even).

Top module: `field_parity_detector`

## Requirements
- R1: While `rst_n` is low at a clock edge, the field level and the parity state go to 0 at that edge.
- R2: After a field whose trailing half line leaves an odd count of sync rising edges since the last clearing gap, `field_odd` is 1 once the vertical pulse has been captured.
- R3: After a field with no trailing half line and an even count of sync rising edges since the last clearing gap, `field_odd` is 0 once the vertical pulse has been captured.
- R4: `field_odd` changes only on the clock edge that first sees `vsync_in` high. Sync pulses while `vsync_in` stays high, and all activity between vertical pulses, leave it unchanged.
- R5: The gap timer restarts while `sync_in` is high. A low gap of G cycles with G >= `gap_limit` clears the parity state to 0, including the case G == `gap_limit`.
- R6: A low gap of G cycles with G < `gap_limit` leaves the parity state unchanged. With `gap_limit` one above the full-line gap, the parity keeps counting across whole lines.
- R7: `field_odd` takes the parity state held at the edge where `vsync_in` is first seen high, one clock after that edge's input. The value is 1 for an odd count of sync rising edges since the last clearing gap and 0 for an even count.
- R8: The parity state flips once per rising edge of `sync_in`, whatever the pulse width. A broad pulse counts as one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sync_in | input | 1 | Composite sync, 1 while a sync pulse is present |
| vsync_in | input | 1 | Vertical pulse, 1 during the vertical output pulse |
| gap_limit | input | GAP_W | Clearing threshold in clock cycles, nominally three quarters of a line |
| field_odd | output | 1 | Field level: 1 for the odd field, 0 for the even field |

## Verification
A parity state that is off by one count, or a threshold compared with the wrong sense, inverts `field_odd` on the very next vertical pulse. The error then persists for every field, because the level stays in step with the wrong phase. A capture that fires on the vertical level rather than its edge shows up during the broad pulses of the same vertical interval: the level flips before `vsync_in` falls. An off-by-one in the gap length appears only when the threshold sits exactly at a gap length. The boundary fields use such a threshold, so the fault shows on their first vertical pulse.

// File: rtl/fd_pkg.sv
// Shared types for the field parity detector.
// Assumes: field level 1 marks the field that ends with a half line.
package fd_pkg;
    typedef enum logic {
        FIELD_EVEN = 1'b0,
        FIELD_ODD  = 1'b1
    } field_e;
endpackage

// File: rtl/fd_rise_detect.sv
// One-cycle pulse on the first cycle a level input is seen high.
// Assumes: the input is already synchronous to clk.
module fd_rise_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    output logic rise_out
);
    logic level_q;

    // Remember last cycle's level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level_in;
    end

    assign rise_out = level_in & ~level_q;
endmodule

// File: rtl/fd_gap_timer.sv
// Counts cycles of a low sync gap and flags when the gap has reached
// the threshold. The count restarts while sync is high and saturates
// at its maximum value.
// Assumes: gap_limit is held steady while a gap is measured.
module fd_gap_timer #(
    parameter int GAP_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_in,
    input  logic [GAP_W-1:0] gap_limit,
    output logic [GAP_W-1:0] gap_cnt,
    output logic             gap_hit
);
    localparam int EXT_W = GAP_W + 1;

    logic [EXT_W-1:0] run_len;

    // Gap length counter: clears on sync, counts up while low.
    always_ff @(posedge clk) begin
        if (!rst_n)                gap_cnt <= '0;
        else if (sync_in)          gap_cnt <= '0;
        else if (gap_cnt != '1)    gap_cnt <= gap_cnt + 1'b1;
    end

    // Length of the gap including the current low cycle.
    assign run_len = {1'b0, gap_cnt} + EXT_W'(1);
    assign gap_hit = ~sync_in & (run_len >= {1'b0, gap_limit});
endmodule

// File: rtl/fd_parity_flop.sv
// Parity flop: flips on each step pulse, returns to zero on clear.
// Assumes: step and clear are never high in the same cycle.
module fd_parity_flop (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic clear,
    output logic tog_q
);
    // Track pulse-count parity since the last clearing gap.
    always_ff @(posedge clk) begin
        if (!rst_n)     tog_q <= 1'b0;
        else if (clear) tog_q <= 1'b0;
        else if (step)  tog_q <= ~tog_q;
    end
endmodule

// File: rtl/field_parity_detector.sv
// Top: derives the interlaced field level from a sync parity flop
// captured at the start of each vertical pulse.
// Assumes: sync_in and vsync_in are synchronous to clk, and gap_limit
// lies between the half-line and the full-line gap lengths.
module field_parity_detector #(
    parameter int GAP_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_in,
    input  logic             vsync_in,
    input  logic [GAP_W-1:0] gap_limit,
    output logic             field_odd
);
    import fd_pkg::*;

    logic             sync_rise;
    logic             vs_rise;
    logic             gap_hit;
    logic [GAP_W-1:0] gap_cnt;
    logic             tog_q;
    field_e           field_q;

    fd_rise_detect sync_edge_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_in (sync_in),
        .rise_out (sync_rise)
    );

    fd_rise_detect vs_edge_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_in (vsync_in),
        .rise_out (vs_rise)
    );

    fd_gap_timer #(.GAP_W(GAP_W)) gap_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_in   (sync_in),
        .gap_limit (gap_limit),
        .gap_cnt   (gap_cnt),
        .gap_hit   (gap_hit)
    );

    fd_parity_flop parity_i (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (sync_rise),
        .clear (gap_hit),
        .tog_q (tog_q)
    );

    // Capture the parity once per vertical pulse and hold it.
    always_ff @(posedge clk) begin
        if (!rst_n)       field_q <= FIELD_EVEN;
        else if (vs_rise) field_q <= field_e'(tog_q);
    end

    assign field_odd = field_q;
endmodule

// File: rtl/fd_checker.sv
// Property checker for field_parity_detector, attached by bind.
// Assumes: it watches the top's ports and the signals passed between
// its sub-blocks.
module fd_checker #(
    parameter int GAP_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sync_in,
    input logic             vsync_in,
    input logic             field_odd,
    input logic             tog_q,
    input logic             gap_hit,
    input logic [GAP_W-1:0] gap_cnt
);
    logic sync_prev;
    logic vs_prev;

    // Private edge history, independent of the design's detectors.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_prev <= 1'b0;
            vs_prev   <= 1'b0;
        end else begin
            sync_prev <= sync_in;
            vs_prev   <= vsync_in;
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (field_odd == 1'b0 && tog_q == 1'b0));

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(vsync_in && !vs_prev) |=> $stable(field_odd));

    p_gap_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sync_in |=> (gap_cnt == '0));

    p_gap_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        gap_hit |=> !tog_q);

    p_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (vsync_in && !vs_prev) |=> (field_odd == $past(tog_q)));

    p_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_in && !sync_prev) |=> (tog_q != $past(tog_q)));
endmodule

bind field_parity_detector fd_checker #(.GAP_W(GAP_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_in   (sync_in),
    .vsync_in  (vsync_in),
    .field_odd (field_odd),
    .tog_q     (tog_q),
    .gap_hit   (gap_hit),
    .gap_cnt   (gap_cnt)
);

// File: tb/field_parity_detector_tb_top.sv
`timescale 1ns/1ps
module field_parity_detector_tb_top;
    localparam int GAP_W = 10;
    localparam int LINE  = 64;
    localparam int HALF  = 32;
    localparam int HW    = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sync_in = 1'b0;
    logic vsync_in = 1'b0;
    logic [GAP_W-1:0] gap_limit = GAP_W'(48);
    logic field_odd;

    int   n_chk = 0;
    int   n_err = 0;
    int   thr = 48;
    int   m_cnt = 0;
    logic last_field = 1'b0;
    bit   done = 1'b0;

    field_parity_detector #(.GAP_W(GAP_W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_in   (sync_in),
        .vsync_in  (vsync_in),
        .gap_limit (gap_limit),
        .field_odd (field_odd)
    );

    always #2.5 clk = ~clk;

    function automatic logic parity_of(int cnt);
        return cnt[0];
    endfunction

    task automatic check(string req, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(int w);
        sync_in = 1'b1;
        tick(w);
        sync_in = 1'b0;
        m_cnt++;
    endtask

    task automatic gap(int g);
        tick(g);
        if (g >= thr) m_cnt = 0;
    endtask

    task automatic set_thr(int t);
        thr = t;
        gap_limit = GAP_W'(t);
    endtask

    task automatic field(bit odd, int nl, int neq, int ew, string tag);
        logic exp;
        for (int i = 0; i < nl; i++) begin pulse(HW); gap(LINE - HW); end
        if (odd) begin pulse(HW); gap(HALF - HW); end
        for (int i = 0; i < neq - 1; i++) begin pulse(ew); gap(HALF - ew); end
        pulse(ew);
        tick(8);
        check({"R4 hold before vertical ", tag}, field_odd, last_field);
        exp = parity_of(m_cnt);
        vsync_in = 1'b1;
        check({"R7 no change before capture edge ", tag}, field_odd, last_field);
        tick(1);
        check({exp ? "R2 R7 odd level " : "R3 R7 even level ", tag}, field_odd, exp);
        last_field = exp;
        tick(HALF - ew - 9);
        if (HALF - ew >= thr) m_cnt = 0;
        repeat (3) begin pulse(HALF - 6); gap(6); end
        check({"R4 hold during vertical ", tag}, field_odd, last_field);
        vsync_in = 1'b0;
        repeat (4) begin pulse(ew); gap(HALF - ew); end
        check({"R4 hold after vertical ", tag}, field_odd, last_field);
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        int nl;
        void'($urandom(32'd20240611));
        tick(5);
        check("R1 reset level", field_odd, 1'b0);
        rst_n = 1'b1;
        tick(2);
        check("R1 level after release", field_odd, 1'b0);
        repeat (3) begin pulse(HW); gap(LINE - HW); end

        // Alternating fields: output must alternate 1,0,1,0.
        for (int k = 0; k < 4; k++) field(k % 2 == 0, 3, 6, HW, "alternate");

        // Randomised fields.
        for (int k = 0; k < 12; k++)
            field(1'($urandom_range(0, 1)), $urandom_range(2, 5),
                  $urandom_range(3, 7), $urandom_range(2, 6), "random");

        // R8: broad equalizing pulses each count once.
        field(1'b1, 3, 6, 20, "R8 broad pulses");
        field(1'b0, 3, 5, 20, "R8 broad pulses");

        // R5: threshold equal to the full-line gap still clears.
        set_thr(LINE - HW);
        field(1'b0, 3, 4, HW, "R5 gap equals limit");
        field(1'b1, 3, 4, HW, "R5 gap equals limit");

        // R6: threshold one above the full-line gap never clears.
        set_thr(LINE - HW + 1);
        nl = ((m_cnt + 3 + 4) % 2 == 1) ? 3 : 2;
        field(1'b0, nl, 4, HW, "R6 gap below limit");
        check("R6 parity kept across lines", last_field, 1'b1);
        set_thr(48);

        // R1: synchronous reset while the level is high.
        field(1'b1, 3, 6, HW, "pre-reset");
        rst_n = 1'b0;
        tick(1);
        check("R1 reset clears high level", field_odd, 1'b0);
        tick(2);
        rst_n = 1'b1;
        m_cnt = 0;
        last_field = 1'b0;
        field(1'b0, 3, 6, HW, "after reset");

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end
endmodule